// File: doc/BRIEF.md
# Narrow-Port Width Converter with Selectable Byte Order

This block joins a 36-bit word queue to an external port that may carry a whole word, half a word (18 bits) or a quarter word (9 bits) per transfer. In the outbound direction it takes each word offered by the queue's read side and presents it as one, two or four consecutive transfers. The queue entry is released only once the final piece has been taken. In the inbound direction it collects one, two or four transfers into a holding register and offers the finished word to the queue's write side.

The transfer width and the piece order are sampled from configuration inputs while reset is held. Big-endian order sends the most significant piece first. Little-endian order sends the least significant piece first. Narrow pieces travel on the low bits of the 36-bit port, and the unused upper bits read as zero. Every edge of the block uses a valid/ready handshake. The queue storage, its flags and any clock crossing are outside this block.

Top module: `bus_width_bridge`

## Requirements
- R1: `cfg_width` (0 = 36-bit, 1 = 18-bit, 2 = 9-bit, 3 treated as 36-bit) and `cfg_big_endian` (1 = big) are captured only while `rst_n` is low; changes after reset have no effect.
- R2: In 36-bit mode the outbound port shows the whole queue word, and every accepted transfer releases one queue entry.
- R3: In 18-bit mode each word goes out as two transfers on bits 17:0, with bits 35:18 zero: big-endian sends word bits 35:18 then 17:0, and little-endian sends the reverse.
- R4: In 9-bit mode each word goes out as four transfers on bits 8:0, with the rest zero: big-endian sends bits 35:27, 26:18, 17:9, 8:0, and little-endian sends the reverse.
- R5: `port_out_valid` follows `fifo_rd_valid`. `fifo_rd_pop` is high only in the cycle the last piece is accepted. Without `port_out_ready` the piece position does not advance.
- R6: In 36-bit mode one inbound transfer forms one word, offered on `fifo_wr_data` in the cycle after acceptance.
- R7: In 18-bit mode two inbound transfers (bits 17:0) form a word, placed in the same order as R3.
- R8: In 9-bit mode four inbound transfers (bits 8:0) form a word, placed in the same order as R4.
- R9: `fifo_wr_valid` rises only after the last piece is accepted. While a word is held and `fifo_wr_ready` is low, the word stays stable and `port_in_ready` is low. When `fifo_wr_ready` is high, a new piece can be accepted in the same cycle as the push.
- R10: Reset returns both piece positions to the first piece and drops `fifo_wr_valid`; `port_in_ready` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while low |
| cfg_width | input | 2 | Transfer width select |
| cfg_big_endian | input | 1 | 1 = most significant piece first |
| fifo_rd_data | input | 36 | Word at the head of the outbound queue |
| fifo_rd_valid | input | 1 | Outbound queue has a word |
| fifo_rd_pop | output | 1 | Release the head word |
| port_out_data | output | 36 | Outbound piece, right-aligned |
| port_out_valid | output | 1 | Outbound piece is valid |
| port_out_ready | input | 1 | External side takes the outbound piece |
| port_in_data | input | 36 | Inbound piece, right-aligned |
| port_in_valid | input | 1 | Inbound piece is valid |
| port_in_ready | output | 1 | Block accepts the inbound piece |
| fifo_wr_data | output | 36 | Assembled word for the inbound queue |
| fifo_wr_valid | output | 1 | Assembled word is ready to push |
| fifo_wr_ready | input | 1 | Inbound queue accepts the word |

## Verification
The hardest situation to reach from the ports is a reset that arrives partway through a word, combined with a configuration change made after reset. The bench starts a 9-bit sequence and stalls it. It then moves the width input while the block is running and shows that the piece order is unchanged. Finally it resets midway through a word and confirms that the first piece comes back. The inbound path is also driven into the state where a finished word is held and the queue refuses it, and then into the state where a push and a new accept happen in the same cycle.

// File: rtl/bwb_pkg.sv
// Shared types and piece-ordering helpers for the width converter.
// Assumes a word splits into at most four pieces.
package bwb_pkg;
    typedef enum logic [1:0] {
        MODE_LONG = 2'd0,
        MODE_HALF = 2'd1,
        MODE_BYTE = 2'd2
    } mode_t;

    // Index of the final piece for a mode.
    function automatic logic [1:0] last_part(mode_t m);
        case (m)
            MODE_HALF: return 2'd1;
            MODE_BYTE: return 2'd3;
            default:   return 2'd0;
        endcase
    endfunction

    // Slice of the word (0 = least significant) carried by piece 'part'.
    function automatic logic [1:0] slice_of(mode_t m, logic be, logic [1:0] part);
        return be ? (last_part(m) - part) : part;
    endfunction
endpackage

// File: rtl/bwb_cfg.sv
// Configuration latch: samples width and order only while reset is asserted.
// Assumes a synchronous active-low reset held for at least one edge.
module bwb_cfg (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_big_endian,
    output bwb_pkg::mode_t    mode_q,
    output logic              be_q
);
    import bwb_pkg::*;

    // Capture configuration during reset, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            case (cfg_width)
                2'd1:    mode_q <= MODE_HALF;
                2'd2:    mode_q <= MODE_BYTE;
                default: mode_q <= MODE_LONG;
            endcase
            be_q <= cfg_big_endian;
        end
    end

    assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(mode_q) && $stable(be_q)));
endmodule

// File: rtl/bwb_split.sv
// Outbound splitter: presents a queue word as 1, 2 or 4 right-aligned pieces.
// Assumes the head word stays stable until it is popped.
module bwb_split #(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bwb_pkg::mode_t    mode,
    input  logic              be,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_pop,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    import bwb_pkg::*;
    localparam int HALF_W = WORD_W / 2;
    localparam int BYTE_W = WORD_W / 4;

    logic [1:0] cnt;
    logic [1:0] idx;
    logic       is_last;

    // Select the piece for the current position.
    always_comb begin
        idx      = slice_of(mode, be, cnt);
        is_last  = (cnt == last_part(mode));
        out_data = '0;
        case (mode)
            MODE_HALF: out_data[HALF_W-1:0] = in_word[32'(idx[0]) * HALF_W +: HALF_W];
            MODE_BYTE: out_data[BYTE_W-1:0] = in_word[32'(idx) * BYTE_W +: BYTE_W];
            default:   out_data = in_word;
        endcase
    end

    assign out_valid = in_valid;
    assign in_pop    = in_valid && out_ready && is_last;

    // Advance the piece position on each accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (in_valid && out_ready) cnt <= is_last ? 2'd0 : cnt + 2'd1;
    end

    assert_pop_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop |=> (cnt == 2'd0));
    assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(cnt));
    assert_half_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALF) |-> (out_data[WORD_W-1:HALF_W] == '0));
    assert_byte_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BYTE) |-> (out_data[WORD_W-1:BYTE_W] == '0));
    assert_cnt_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (cnt == 2'd0));
endmodule

// File: rtl/bwb_gather.sv
// Inbound gatherer: collects 1, 2 or 4 right-aligned pieces into one word.
// Assumes the queue may hold off the push for any number of cycles.
module bwb_gather #(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bwb_pkg::mode_t    mode,
    input  logic              be,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_valid,
    input  logic              wr_ready
);
    import bwb_pkg::*;
    localparam int HALF_W = WORD_W / 2;
    localparam int BYTE_W = WORD_W / 4;

    logic [1:0]        cnt;
    logic [1:0]        idx;
    logic              hold;
    logic [WORD_W-1:0] acc;
    logic              accept;
    logic              is_last;

    // Decode the slice position and the handshake.
    always_comb begin
        idx      = slice_of(mode, be, cnt);
        is_last  = (cnt == last_part(mode));
        in_ready = !hold || wr_ready;
        accept   = in_valid && in_ready;
    end

    assign wr_data  = acc;
    assign wr_valid = hold;

    // Place accepted pieces and track the finished-word hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            hold <= 1'b0;
            acc  <= '0;
        end else begin
            if (hold && wr_ready) hold <= 1'b0;
            if (accept) begin
                case (mode)
                    MODE_HALF: acc[32'(idx[0]) * HALF_W +: HALF_W] <= in_data[HALF_W-1:0];
                    MODE_BYTE: acc[32'(idx) * BYTE_W +: BYTE_W]    <= in_data[BYTE_W-1:0];
                    default:   acc <= in_data;
                endcase
                if (is_last) begin
                    cnt  <= 2'd0;
                    hold <= 1'b1;
                end else begin
                    cnt  <= cnt + 2'd1;
                end
            end
        end
    end

    assert_held_word_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
    assert_push_follows_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(in_valid && in_ready));
    assert_wr_clear_R10: assert property (@(posedge clk)
        !rst_n |=> !wr_valid);
endmodule

// File: rtl/bus_width_bridge.sv
// Top level: configuration latch plus the outbound splitter and inbound gatherer.
// Assumes both queue sides share this block's clock.
module bus_width_bridge #(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_big_endian,
    input  logic [WORD_W-1:0] fifo_rd_data,
    input  logic              fifo_rd_valid,
    output logic              fifo_rd_pop,
    output logic [WORD_W-1:0] port_out_data,
    output logic              port_out_valid,
    input  logic              port_out_ready,
    input  logic [WORD_W-1:0] port_in_data,
    input  logic              port_in_valid,
    output logic              port_in_ready,
    output logic [WORD_W-1:0] fifo_wr_data,
    output logic              fifo_wr_valid,
    input  logic              fifo_wr_ready
);
    bwb_pkg::mode_t mode_q;
    logic           be_q;

    bwb_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
        .cfg_big_endian(cfg_big_endian), .mode_q(mode_q), .be_q(be_q)
    );

    bwb_split #(.WORD_W(WORD_W)) u_split (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .be(be_q),
        .in_word(fifo_rd_data), .in_valid(fifo_rd_valid), .in_pop(fifo_rd_pop),
        .out_data(port_out_data), .out_valid(port_out_valid), .out_ready(port_out_ready)
    );

    bwb_gather #(.WORD_W(WORD_W)) u_gather (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .be(be_q),
        .in_data(port_in_data), .in_valid(port_in_valid), .in_ready(port_in_ready),
        .wr_data(fifo_wr_data), .wr_valid(fifo_wr_valid), .wr_ready(fifo_wr_ready)
    );
endmodule

// File: tb/bus_width_bridge_bench.sv
module bus_width_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_big_endian = 1'b1;
    logic [35:0] fifo_rd_data = '0;
    logic        fifo_rd_valid = 1'b0;
    logic        fifo_rd_pop;
    logic [35:0] port_out_data;
    logic        port_out_valid;
    logic        port_out_ready = 1'b0;
    logic [35:0] port_in_data = '0;
    logic        port_in_valid = 1'b0;
    logic        port_in_ready;
    logic [35:0] fifo_wr_data;
    logic        fifo_wr_valid;
    logic        fifo_wr_ready = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    bus_width_bridge u_bus_width_bridge (.*);

    localparam logic [8:0]  B3 = 9'h1A1, B2 = 9'h0B2, B1 = 9'h0C3, B0 = 9'h1D4;
    localparam logic [35:0] WRD  = {B3, B2, B1, B0};
    localparam logic [35:0] H_HI = {18'd0, B3, B2};
    localparam logic [35:0] H_LO = {18'd0, B1, B0};
    localparam logic [35:0] Y3 = {27'd0, B3}, Y2 = {27'd0, B2}, Y1 = {27'd0, B1}, Y0 = {27'd0, B0};

    typedef struct packed {
        logic [1:0]       mode;
        logic             be;
        logic [2:0]       n;
        logic [3:0][35:0] exp;   // exp[k] is piece k in transfer order
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 1'b1, 3'd1, {108'd0, WRD}},
        '{2'd0, 1'b0, 3'd1, {108'd0, WRD}},
        '{2'd1, 1'b1, 3'd2, {72'd0, H_LO, H_HI}},
        '{2'd1, 1'b0, 3'd2, {72'd0, H_HI, H_LO}},
        '{2'd2, 1'b1, 3'd4, {Y0, Y1, Y2, Y3}},
        '{2'd2, 1'b0, 3'd4, {Y3, Y2, Y1, Y0}}
    };

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] w, input logic be);
        @(negedge clk);
        cfg_width = w; cfg_big_endian = be; rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic string rd_tag(input logic [1:0] m);
        return (m == 2'd0) ? "R2" : (m == 2'd1) ? "R3" : "R4";
    endfunction
    function automatic string wr_tag(input logic [1:0] m);
        return (m == 2'd0) ? "R6" : (m == 2'd1) ? "R7" : "R8";
    endfunction

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R10: state coming out of reset
        do_reset(2'd2, 1'b1);
        #1;
        chk("R10 wr_valid", {35'd0, fifo_wr_valid}, 36'd0);
        chk("R10 in_ready", {35'd0, port_in_ready}, 36'd1);
        chk("R10 pop idle", {35'd0, fifo_rd_pop}, 36'd0);

        // Table walk: outbound pieces and inbound assembly per mode/order
        foreach (VECS[i]) begin
            do_reset(VECS[i].mode, VECS[i].be);
            fifo_rd_data = WRD; fifo_rd_valid = 1'b1; port_out_ready = 1'b1;
            for (int k = 0; k < int'(VECS[i].n); k++) begin
                #1;
                chk(rd_tag(VECS[i].mode), port_out_data, VECS[i].exp[k]);
                chk("R5 pop", {35'd0, fifo_rd_pop}, (k == int'(VECS[i].n) - 1) ? 36'd1 : 36'd0);
                @(negedge clk);
            end
            fifo_rd_valid = 1'b0; port_out_ready = 1'b0;
            fifo_wr_ready = 1'b0;
            for (int k = 0; k < int'(VECS[i].n); k++) begin
                port_in_data = VECS[i].exp[k]; port_in_valid = 1'b1;
                #1;
                chk("R9 no early push", {35'd0, fifo_wr_valid}, 36'd0);
                @(negedge clk);
            end
            port_in_valid = 1'b0;
            #1;
            chk("R9 push valid", {35'd0, fifo_wr_valid}, 36'd1);
            chk(wr_tag(VECS[i].mode), fifo_wr_data, WRD);
            fifo_wr_ready = 1'b1;
            @(negedge clk);
            #1;
            chk("R9 push done", {35'd0, fifo_wr_valid}, 36'd0);
            fifo_wr_ready = 1'b0;
        end

        // R1: change width after reset; 9-bit big-endian order must persist
        do_reset(2'd2, 1'b1);
        cfg_width = 2'd0; cfg_big_endian = 1'b0;
        fifo_rd_data = WRD; fifo_rd_valid = 1'b1; port_out_ready = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 cfg ignored", port_out_data, Y3);
        // R5: stall holds position and never pops
        chk("R5 stall no pop", {35'd0, fifo_rd_pop}, 36'd0);
        chk("R5 valid follows", {35'd0, port_out_valid}, 36'd1);
        port_out_ready = 1'b1;
        @(negedge clk);
        #1;
        chk("R5 advance", port_out_data, Y2);
        // R10: reset mid-word returns to first piece
        do_reset(2'd2, 1'b1);
        #1;
        chk("R10 restart", port_out_data, Y3);
        fifo_rd_valid = 1'b0; port_out_ready = 1'b0;

        // R9: held word with queue refusing, then push and accept together
        fifo_wr_ready = 1'b0;
        for (int k = 0; k < 4; k++) begin
            port_in_data = VECS[4].exp[k]; port_in_valid = 1'b1;
            @(negedge clk);
        end
        port_in_data = Y3;
        #1;
        chk("R9 blocked", {35'd0, port_in_ready}, 36'd0);
        @(negedge clk);
        #1;
        chk("R9 held", fifo_wr_data, WRD);
        fifo_wr_ready = 1'b1;
        #1;
        chk("R9 ready with push", {35'd0, port_in_ready}, 36'd1);
        @(negedge clk);
        port_in_valid = 1'b0; fifo_wr_ready = 1'b0;
        #1;
        chk("R9 pushed", {35'd0, fifo_wr_valid}, 36'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule